// File: doc/BRIEF.md
# PCI Host Bridge Address Decoder

This block sits between a 32-bit processor bus and the downstream targets of a PCI host bridge. Each processor access is sorted into one of five windows: PCI I/O, direct-mapped configuration, interrupt acknowledge, PCI memory, or the boot ROM at the top of the address space. The block emits the window code together with the address translated into that window's own space. An access that falls in no window, or that uses an illegal size, is flagged as a decode error.

I/O accesses have two run-time mappings. The contiguous mapping keeps only the low 16 offset bits. The sparse mapping folds an 8 MB processor range into a 64 KB space by dropping offset bits 11..5. Configuration accesses carry a one-hot device select in the address, and the block turns it into a binary device number. Write data is packed little-endian into the low lanes, with byte enables for 1-, 2- and 4-byte accesses.

The block takes each request on a valid/ready handshake. The result is registered and appears one clock later.

Top module: `pchd_host_decoder`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high. The result shows on `rsp_valid` at the next clock and is held unchanged until `rsp_ready` is high. `req_ready` is high whenever no result is held, or when the held result is being taken in the same cycle.
- R2: Synchronous reset clears `rsp_valid` and returns the I/O mapping to contiguous. A request taken at the first edge after reset uses the contiguous mapping, even when `io_sparse` was high during reset.
- R3: With contiguous mapping, an address in 0x80000000..0x807FFFFF gives target code 0 (I/O), and the translated address is the window offset masked to bits [15:0].
- R4: With sparse mapping, an address in the I/O window gives target code 0. Offset bits [4:0] pass to output bits [4:0], and offset bits [22:12] move to output bits [15:5].
- R5: The mapping in force is `io_sparse` as sampled at the previous clock edge. Changing `io_sparse` in the same cycle as a request does not affect that request.
- R6: An address in 0x80800000..0x80BFFFFF gives target code 1 (configuration). The index (0..10) of the lowest set bit among address bits 11..21 goes to output bits [14:11], and address bits [10:0] pass through.
- R7: A configuration address with none of bits 11..21 set gives device number 11.
- R8: A 1-byte read of 0xBFFFFFF0 gives target code 2 (interrupt acknowledge) with address 0. A write, or any other size, at that address is a decode error.
- R9: An address in 0xC0000000..0xFEFFFFFF gives target code 3 (PCI memory), and the translated address is the processor address minus 0xC0000000.
- R10: An address in 0xFFF00000..0xFFFFFFFF gives target code 4 (ROM), and the translated address is the offset in bits [19:0]. A write there comes out with `rsp_write` and `rsp_be` cleared, with no error.
- R11: An address that hits no window, or a size code of 3, gives `rsp_err`=1 and target code 7. It also gives address 0, `rsp_write`=0, `rsp_be`=0 and `rsp_data` all ones.
- R12: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. `rsp_be` sets its low 1, 2 or 4 bits. A write places byte k of `req_wdata` in lane k and zeroes the unused upper lanes, while a read returns zero data. Unaligned addresses are taken unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sparse | input | 1 | I/O mapping select, 1 = sparse |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Processor address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4 bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Decoded result present |
| rsp_ready | input | 1 | Result taken |
| rsp_target | output | 3 | Target code (0 I/O, 1 cfg, 2 ack, 3 mem, 4 ROM, 7 none) |
| rsp_addr | output | 32 | Translated downstream address |
| rsp_write | output | 1 | Write to forward |
| rsp_be | output | 4 | Byte enables, lane 0 lowest |
| rsp_data | output | 32 | Packed write data, or all ones on error |
| rsp_err | output | 1 | Decode error |

## Verification
I/O addresses go through both mappings. The sparse case uses offsets with bits set both between 5 and 11 and above 12, so a wrong shift or mask shows. Configuration addresses cover a single select bit, several select bits (only the lowest may win), and no select bit. Accesses also land on each window edge and in the gaps around them, and on the interrupt-acknowledge byte with legal and illegal sizes. A mode change in the same cycle as a request, and output stalls, separate sampling-time and holding faults from decode faults.

// File: rtl/pchd_pkg.sv
package pchd_pkg;
  typedef enum logic [2:0] {
    TGT_IO   = 3'd0,
    TGT_CFG  = 3'd1,
    TGT_IACK = 3'd2,
    TGT_MEM  = 3'd3,
    TGT_ROM  = 3'd4,
    TGT_NONE = 3'd7
  } tgt_e;
endpackage

// File: rtl/pchd_window_sel.sv
module pchd_window_sel
  import pchd_pkg::*;
#(
  parameter int             AW        = 32,
  parameter logic [AW-1:0]  IO_BASE   = 32'h8000_0000,
  parameter int             IO_LG2    = 23,
  parameter logic [AW-1:0]  CFG_BASE  = 32'h8080_0000,
  parameter int             CFG_LG2   = 22,
  parameter logic [AW-1:0]  IACK_ADDR = 32'hBFFF_FFF0,
  parameter logic [AW-1:0]  MEM_BASE  = 32'hC000_0000,
  parameter logic [AW-1:0]  MEM_LAST  = 32'hFEFF_FFFF,
  parameter int             ROM_LG2   = 20
) (
  input  logic [AW-1:0] addr,
  output tgt_e          win,
  output logic [AW-1:0] off
);
  always_comb begin
    win = TGT_NONE;
    off = '0;
    if (addr[AW-1:IO_LG2] == IO_BASE[AW-1:IO_LG2]) begin
      win = TGT_IO;
      off = addr - IO_BASE;
    end else if (addr[AW-1:CFG_LG2] == CFG_BASE[AW-1:CFG_LG2]) begin
      win = TGT_CFG;
      off = addr - CFG_BASE;
    end else if (addr == IACK_ADDR) begin
      win = TGT_IACK;
    end else if (addr >= MEM_BASE && addr <= MEM_LAST) begin
      win = TGT_MEM;
      off = addr - MEM_BASE;
    end else if (&addr[AW-1:ROM_LG2]) begin
      win = TGT_ROM;
      off = AW'(addr[ROM_LG2-1:0]);
    end
  end
endmodule

// File: rtl/pchd_io_xlate.sv
module pchd_io_xlate #(
  parameter int AW        = 32,
  parameter int CONTIG_W  = 16,
  parameter int KEEP_LO   = 5,
  parameter int FOLD      = 7,
  parameter int SPARSE_HI = 22
) (
  input  logic                 sparse,
  input  logic [SPARSE_HI:0]   off,
  output logic [AW-1:0]        addr
);
  localparam int UP_LO = KEEP_LO + FOLD;
  localparam int UP_W  = SPARSE_HI - UP_LO + 1;

  logic [UP_W+KEEP_LO-1:0] folded;
  assign folded = {off[SPARSE_HI:UP_LO], off[KEEP_LO-1:0]};

  always_comb begin
    if (sparse) addr = AW'(folded);
    else        addr = AW'(off[CONTIG_W-1:0]);
  end
endmodule

// File: rtl/pchd_cfg_xlate.sv
module pchd_cfg_xlate #(
  parameter int AW     = 32,
  parameter int PASS_W = 11,
  parameter int SEL_N  = 11
) (
  input  logic [PASS_W+SEL_N-1:0] off,
  output logic [AW-1:0]           addr
);
  localparam int DEV_W = $clog2(SEL_N + 1);

  logic [DEV_W-1:0] dev;

  always_comb begin
    dev = DEV_W'(SEL_N);
    for (int i = SEL_N - 1; i >= 0; i--) begin
      if (off[PASS_W + i]) dev = DEV_W'(i);
    end
  end

  assign addr = AW'({dev, off[PASS_W-1:0]});
endmodule

// File: rtl/pchd_host_decoder.sv
module pchd_host_decoder
  import pchd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int IO_LG2    = 23,
  parameter int CFG_LG2   = 22,
  parameter int CONTIG_W  = 16,
  parameter int CFG_PASS  = 11,
  parameter int ROM_LG2   = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_sparse,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [2:0]    rsp_target,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_write,
  output logic [DW/8-1:0] rsp_be,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err
);
  localparam int BE_W    = DW / 8;
  localparam int IO_HI   = IO_LG2 - 1;
  localparam int CFG_SEL = CFG_LG2 - CFG_PASS;

  logic          mode_q;
  tgt_e          win;
  logic [AW-1:0] win_off, io_addr, cfg_addr;

  pchd_window_sel #(.AW(AW), .IO_LG2(IO_LG2), .CFG_LG2(CFG_LG2), .ROM_LG2(ROM_LG2))
    u_win (.addr(req_addr), .win(win), .off(win_off));

  pchd_io_xlate #(.AW(AW), .CONTIG_W(CONTIG_W), .SPARSE_HI(IO_HI))
    u_io (.sparse(mode_q), .off(win_off[IO_HI:0]), .addr(io_addr));

  pchd_cfg_xlate #(.AW(AW), .PASS_W(CFG_PASS), .SEL_N(CFG_SEL))
    u_cfg (.off(win_off[CFG_LG2-1:0]), .addr(cfg_addr));

  int              nbytes;
  logic            size_ok, nxt_err, nxt_write;
  tgt_e            nxt_tgt;
  logic [AW-1:0]   nxt_addr;
  logic [BE_W-1:0] nxt_be;
  logic [DW-1:0]   nxt_data;

  always_comb begin
    nbytes  = 1 << req_size;
    size_ok = nbytes <= BE_W;
    for (int b = 0; b < BE_W; b++) begin
      nxt_be[b]         = (b < nbytes);
      nxt_data[8*b +: 8] = (req_write && b < nbytes) ? req_wdata[8*b +: 8] : 8'h00;
    end
    nxt_tgt   = win;
    nxt_write = req_write;
    case (win)
      TGT_IO:           nxt_addr = io_addr;
      TGT_CFG:          nxt_addr = cfg_addr;
      TGT_MEM, TGT_ROM: nxt_addr = win_off;
      default:          nxt_addr = '0;
    endcase
    if (win == TGT_ROM && req_write) begin
      nxt_write = 1'b0;
      nxt_be    = '0;
    end
    nxt_err = (win == TGT_NONE) || !size_ok ||
              (win == TGT_IACK && (req_write || req_size != 2'd0));
    if (nxt_err) begin
      nxt_tgt   = TGT_NONE;
      nxt_addr  = '0;
      nxt_write = 1'b0;
      nxt_be    = '0;
      nxt_data  = '1;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_target <= 3'(TGT_NONE);
      rsp_addr   <= '0;
      rsp_write  <= 1'b0;
      rsp_be     <= '0;
      rsp_data   <= '0;
      rsp_err    <= 1'b0;
    end else begin
      mode_q <= io_sparse;
      if (req_valid && req_ready) begin
        rsp_valid  <= 1'b1;
        rsp_target <= 3'(nxt_tgt);
        rsp_addr   <= nxt_addr;
        rsp_write  <= nxt_write;
        rsp_be     <= nxt_be;
        rsp_data   <= nxt_data;
        rsp_err    <= nxt_err;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pchd_checker.sv
module pchd_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [2:0]    rsp_target,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_write,
  input logic [DW/8-1:0] rsp_be,
  input logic [DW-1:0] rsp_data,
  input logic          rsp_err
);
  // R1: a stalled result stays put
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) &&
                                $stable(rsp_target) && $stable(rsp_data));
  // R1: an accepted request yields a result next cycle
  a_r1_accept_valid: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);
  // R1: a drained output with no new request goes idle
  a_r1_drain_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready && !req_valid |=> !rsp_valid);
  // R2: no result in the cycle after a reset cycle
  a_r2_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid);
  // R11: error outputs have a fixed shape
  a_r11_error_shape: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_target == 3'd7 && rsp_data == '1 &&
                             !rsp_write && rsp_be == '0);
  // R10: nothing is written toward the ROM
  a_r10_rom_no_write: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_target == 3'd4 |-> !rsp_write);
  // R3: I/O addresses stay inside 64 KB
  a_r3_io_range: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_target == 3'd0 |-> rsp_addr[AW-1:16] == '0);
  // R6: device number never exceeds 11
  a_r6_cfg_dev_range: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_target == 3'd1 |-> rsp_addr[AW-1:15] == '0 &&
                                        rsp_addr[14:11] <= 4'd11);
  // R8: interrupt acknowledge is a single-byte read
  a_r8_iack_shape: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_target == 3'd2 |-> !rsp_write && rsp_be == 4'b0001);
endmodule

bind pchd_host_decoder pchd_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_target(rsp_target),
  .rsp_addr(rsp_addr), .rsp_write(rsp_write), .rsp_be(rsp_be),
  .rsp_data(rsp_data), .rsp_err(rsp_err));

// File: tb/pchd_host_decoder_bench.sv
module pchd_host_decoder_bench;
  logic        clk = 0, rst = 1, io_sparse = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_size = 0;
  logic        req_ready, rsp_valid, rsp_write, rsp_err;
  logic [2:0]  rsp_target;
  logic [31:0] rsp_addr, rsp_data;
  logic [3:0]  rsp_be;

  always #5 clk = ~clk;

  pchd_host_decoder u_pchd_host_decoder (
    .clk(clk), .rst(rst), .io_sparse(io_sparse),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_target(rsp_target),
    .rsp_addr(rsp_addr), .rsp_write(rsp_write), .rsp_be(rsp_be),
    .rsp_data(rsp_data), .rsp_err(rsp_err));

  int checks = 0, fails = 0;

  // reference model state
  logic        m_valid = 0, m_mode = 0, acc_seen = 0, after_rst = 0;
  logic [2:0]  m_tgt;
  logic [31:0] m_addr, m_data;
  logic        m_write, m_err;
  logic [3:0]  m_be;
  string       m_tag = "R1";

  task automatic model(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                       input logic [31:0] wd, input logic md,
                       output logic [2:0] t, output logic [31:0] oa, output logic ow,
                       output logic [3:0] be, output logic [31:0] od,
                       output logic oe, output string tag);
    int nb;
    logic [31:0] off;
    int dev;
    nb = 1 << sz;
    oe = 0; oa = 0; t = 7; tag = "R11";
    if (a >= 32'h8000_0000 && a < 32'h8080_0000) begin
      off = a - 32'h8000_0000; t = 0;
      if (md) begin oa = ((off >> 7) & 32'hFFE0) | (off & 32'h1F); tag = "R4"; end
      else    begin oa = off & 32'hFFFF; tag = "R3"; end
    end else if (a >= 32'h8080_0000 && a < 32'h80C0_0000) begin
      off = a - 32'h8080_0000; t = 1; dev = 11;
      for (int i = 10; i >= 0; i--) if (off[11+i]) dev = i;
      oa = (32'(dev) << 11) | (off & 32'h7FF);
      tag = (dev == 11) ? "R7" : "R6";
    end else if (a == 32'hBFFF_FFF0) begin
      t = 2; tag = "R8";
      if (wr || sz != 0) oe = 1;
    end else if (a >= 32'hC000_0000 && a <= 32'hFEFF_FFFF) begin
      t = 3; oa = a - 32'hC000_0000; tag = "R9";
    end else if (a >= 32'hFFF0_0000) begin
      t = 4; oa = a - 32'hFFF0_0000; tag = "R10";
    end else oe = 1;
    if (sz == 3) oe = 1;
    be = 4'((1 << nb) - 1);
    od = wr ? 32'(64'(wd) & ((64'd1 << (8*nb)) - 1)) : 32'd0;
    ow = wr;
    if (t == 4 && wr) begin ow = 0; be = 0; end
    if (oe) begin t = 7; oa = 0; ow = 0; be = 0; od = 32'hFFFF_FFFF; tag = "R11"; end
  endtask

  always @(posedge clk) begin
    logic acc;
    if (rst) begin
      m_valid = 0; m_mode = 0; acc_seen = 0; after_rst = 1;
    end else begin
      acc = req_valid && (!m_valid || rsp_ready);
      acc_seen = acc;
      if (acc) begin
        model(req_addr, req_write, req_size, req_wdata, m_mode,
              m_tgt, m_addr, m_write, m_be, m_data, m_err, m_tag);
        if (after_rst) m_tag = "R2";
        else if (m_tgt == 0 && io_sparse != m_mode) m_tag = "R5";
        m_valid = 1;
        after_rst = 0;
      end else if (rsp_ready) m_valid = 0;
      m_mode = io_sparse;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    #1;
    if (rst) chk("R2", "valid in reset", 32'(rsp_valid), 32'd0);
    else begin
      chk("R1", "rsp_valid", 32'(rsp_valid), 32'(m_valid));
      chk("R1", "req_ready", 32'(req_ready), 32'(!m_valid || rsp_ready));
      if (m_valid) begin
        chk(m_tag, "target", 32'(rsp_target), 32'(m_tgt));
        chk(m_tag, "addr", rsp_addr, m_addr);
        chk(m_tag, "write", 32'(rsp_write), 32'(m_write));
        chk(m_tag, "err", 32'(rsp_err), 32'(m_err));
        chk("R12", "be", 32'(rsp_be), 32'(m_be));
        chk("R12", "data", rsp_data, m_data);
      end
    end
  end

  task automatic send(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                      input logic [31:0] wd);
    @(negedge clk);
    req_addr = a; req_write = wr; req_size = sz; req_wdata = wd; req_valid = 1;
    do @(negedge clk); while (!acc_seen);
    req_valid = 0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    io_sparse = 1;                       // R2: sparse requested during reset
    repeat (3) @(negedge clk);
    rst = 0;
    req_addr = 32'h8012_3456; req_write = 0; req_size = 2; req_valid = 1;
    do @(negedge clk); while (!acc_seen);
    req_valid = 0;
    // R4: sparse mapping, bits set in the folded range and above
    send(32'h8012_3456, 0, 2, 0);
    send(32'h807F_FFFF, 1, 0, 32'hA5A5_A5A5);
    send(32'h8000_0FFF, 0, 1, 0);
    // R5: mode switched in the same cycle as a request
    @(negedge clk);
    io_sparse = 0;
    req_addr = 32'h8055_5555; req_write = 0; req_size = 0; req_valid = 1;
    do @(negedge clk); while (!acc_seen);
    req_valid = 0;
    // R3: contiguous mapping
    send(32'h8001_2345, 1, 1, 32'h1122_3344);
    send(32'h807F_FFFF, 0, 2, 0);
    // R6, R7: configuration decode
    send(32'h8080_27FF, 0, 2, 0);
    send(32'h80A0_8123, 1, 2, 32'hDEAD_BEEF);
    send(32'h80BF_F800, 0, 0, 0);
    send(32'h8080_0004, 0, 2, 0);
    send(32'h80BF_FFFF, 0, 0, 0);
    // R8: interrupt acknowledge
    send(32'hBFFF_FFF0, 0, 0, 0);
    send(32'hBFFF_FFF0, 1, 0, 32'h55);
    send(32'hBFFF_FFF0, 0, 1, 0);
    // R9: PCI memory edges
    send(32'hC000_0000, 0, 2, 0);
    send(32'hFEFF_FFFF, 1, 0, 32'h1234_5678);
    // R10: ROM read and dropped write
    send(32'hFFF0_0010, 0, 2, 0);
    send(32'hFFFF_FFFC, 1, 2, 32'hCAFE_F00D);
    // R11: unmapped and bad size
    send(32'h0000_1000, 0, 2, 0);
    send(32'h80C0_0000, 1, 2, 32'h1);
    send(32'hFF00_0000, 0, 0, 0);
    send(32'hBFFF_FFEF, 0, 0, 0);
    send(32'hC000_0100, 0, 3, 0);
    // R12: unaligned two-byte write keeps its address
    send(32'hC000_0003, 1, 1, 32'hFFEE_DDCC);
    // R1: back-pressure holds the result and blocks the next request
    @(negedge clk);
    rsp_ready = 0;
    send(32'hC000_0040, 0, 2, 0);
    req_addr = 32'h8080_1000; req_write = 0; req_size = 2; req_valid = 1;
    repeat (3) @(negedge clk);
    rsp_ready = 1;
    do @(negedge clk); while (!acc_seen);
    req_valid = 0;
    repeat (4) @(negedge clk);
    summary();
  end
endmodule